// File: doc/BRIEF.md
# Synchronous Serial Clock Output Generator

This block drives the clock pin that accompanies transmitted data when a serial port runs in synchronous mode. The transmitter strobes `bit_stb` once at the start of every data bit cell. In response the block emits exactly one full clock period, aligned to the start of that cell. Start and stop bits carry no strobe, so no pulse appears during them. The idle level of the pin, the half of the cell that holds the active level, and whether the final data bit gets a pulse are all programmable.

The pulse rate comes from the system clock through a 5-bit divider. Each half of a cell lasts `max(div_sel,1)+1` system clocks, which gives a period of twice that and a 50% duty cycle. The divider is captured when the strobe arrives, so a change made mid-cell only affects the next cell. The transmitter is expected to strobe cells `2*(max(div_sel,1)+1)` cycles apart. A strobe that arrives earlier restarts the cell. When synchronous mode is off, the pin stays at its idle level.

Top module: `sclkgen`

## Requirements
- R1: While `rst` is high at a clock edge, `sclk_o` takes the value of `idle_hi`, and no cell is in progress after reset.
- R2: While `sync_en` is low, `sclk_o` equals `idle_hi` one cycle later. Strobes are ignored, and a cell in progress is abandoned within one cycle.
- R3: With `sync_en` high, a `bit_stb` sampled at clock edge k starts a cell. The first half-cell level is visible on `sclk_o` just after edge k.
- R4: Idle level is `idle_hi` (1 = high, 0 = low). The active level during a pulse is its inverse.
- R5: With `late_edge`=0 the first half of the cell is idle and the second half is active, so the pin is active for cycles H..2H-1 after the strobe edge. With `late_edge`=1 the first half is active and the second half is idle.
- R6: Each half-cell lasts H = max(`div_sel`,1)+1 system clocks. `div_sel` values 0 and 1 therefore both give H = 2, and 31 gives H = 32.
- R7: `div_sel` is captured at the strobe. A change during a cell does not alter that cell's timing and applies from the next strobe.
- R8: A strobe with `bit_last`=1 while `last_pulse_en`=0 produces a cell with no pulse: the pin stays idle throughout. With `last_pulse_en`=1 the final cell pulses normally.
- R9: When a cell ends with no new strobe, `sclk_o` is back at idle from cycle 2H after the strobe edge. Strobes spaced 2H apart give gap-free consecutive pulses.
- R10: A strobe arriving during a cell restarts the cell from its first half with a fresh half-cell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Enables synchronous clock output |
| idle_hi | input | 1 | Idle level select (1 = high) |
| late_edge | input | 1 | Active half select (1 = first half active) |
| last_pulse_en | input | 1 | Emit a pulse for the final data bit |
| div_sel | input | DIV_W (5) | Half-cell length select |
| bit_stb | input | 1 | One-cycle strobe at the start of a data bit cell |
| bit_last | input | 1 | Marks the strobed cell as the final data bit |
| sclk_o | output | 1 | Registered clock pin output |

## Verification
Single cells are run in all four combinations of idle level and active half. This separates a polarity error from a phase error, because each combination fixes which samples must show the inverted level. Divider values 0, 1, 2, 3, 7 and 31 are used: 0 against 1 exposes a missing clamp, and 31 exposes truncation of the half-cell count. Multi-cell frames with and without the last-bit pulse distinguish suppression of only the final cell from suppression of every cell. A mid-cell divider change, an early restart strobe and a mid-cell disable show whether the settings are captured at the strobe and whether the cell state is cleared.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } half_e;

  typedef struct packed {
    logic  act;
    half_e half;
    logic  sup;
  } cell_st_t;

endpackage

// File: rtl/sclkgen_halfcnt.sv
module sclkgen_halfcnt #(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [LEN_W-1:0] len,
  output logic             done
);

  logic [LEN_W-1:0] cnt_q;

  assign done = run && (cnt_q == (len - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (done) cnt_q <= '0;
      else      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

endmodule

// File: rtl/sclkgen_cellseq.sv
module sclkgen_cellseq
  import sclkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  localparam int unsigned LEN_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic             last,
  input  logic             lbcp,
  input  logic [DIV_W-1:0] div,
  input  logic             half_done,
  output cell_st_t         st_q,
  output cell_st_t         st_n,
  output logic [LEN_W-1:0] hlen_q
);

  logic [LEN_W-1:0] hlen_n;
  logic [LEN_W-1:0] hlen_new;

  // a zero divider behaves like one; half-cell length is that plus one
  assign hlen_new = (div == '0) ? LEN_W'(2) : (LEN_W'(div) + LEN_W'(1));

  always_comb begin
    st_n   = st_q;
    hlen_n = hlen_q;
    if (!en) begin
      st_n.act  = 1'b0;
      st_n.half = HALF_A;
      st_n.sup  = 1'b0;
    end else if (stb) begin
      st_n.act  = 1'b1;
      st_n.half = HALF_A;
      st_n.sup  = last & ~lbcp;
      hlen_n    = hlen_new;
    end else if (st_q.act && half_done) begin
      if (st_q.half == HALF_B) begin
        st_n.act  = 1'b0;
        st_n.half = HALF_A;
        st_n.sup  = 1'b0;
      end else begin
        st_n.half = HALF_B;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q.act  <= 1'b0;
      st_q.half <= HALF_A;
      st_q.sup  <= 1'b0;
      hlen_q    <= LEN_W'(2);
    end else begin
      st_q   <= st_n;
      hlen_q <= hlen_n;
    end
  end

endmodule

// File: rtl/sclkgen_drive.sv
module sclkgen_drive
  import sclkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cpol,
  input  logic     cpha,
  input  cell_st_t st_n,
  output logic     pin_q
);

  logic pulse_on;

  assign pulse_on = st_n.act && !st_n.sup && ((st_n.half == HALF_B) ^ cpha);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= cpol;
    else     pin_q <= pulse_on ? ~cpol : cpol;
  end

endmodule

// File: rtl/sclkgen.sv
module sclkgen
  import sclkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_en,
  input  logic             idle_hi,
  input  logic             late_edge,
  input  logic             last_pulse_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             bit_stb,
  input  logic             bit_last,
  output logic             sclk_o
);

  localparam int unsigned LEN_W = DIV_W + 1;

  cell_st_t         st_q;
  cell_st_t         st_n;
  logic [LEN_W-1:0] hlen_q;
  logic             half_done;
  logic             cnt_clear;
  logic             cell_act;
  logic             cell_sup;
  half_e            cell_half;

  assign cnt_clear = !sync_en || bit_stb;
  assign cell_act  = st_q.act;
  assign cell_sup  = st_q.sup;
  assign cell_half = st_q.half;

  sclkgen_halfcnt #(.LEN_W(LEN_W)) u_halfcnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clear),
    .run   (cell_act),
    .len   (hlen_q),
    .done  (half_done)
  );

  sclkgen_cellseq #(.DIV_W(DIV_W)) u_cellseq (
    .clk       (clk),
    .rst       (rst),
    .en        (sync_en),
    .stb       (bit_stb),
    .last      (bit_last),
    .lbcp      (last_pulse_en),
    .div       (div_sel),
    .half_done (half_done),
    .st_q      (st_q),
    .st_n      (st_n),
    .hlen_q    (hlen_q)
  );

  sclkgen_drive u_drive (
    .clk   (clk),
    .rst   (rst),
    .cpol  (idle_hi),
    .cpha  (late_edge),
    .st_n  (st_n),
    .pin_q (sclk_o)
  );

endmodule

// File: rtl/sclkgen_chk.sv
module sclkgen_chk
  import sclkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  localparam int unsigned LEN_W = DIV_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_en,
  input logic             idle_hi,
  input logic             bit_stb,
  input logic             sclk_o,
  input logic             cell_act,
  input logic             cell_sup,
  input half_e            cell_half,
  input logic [LEN_W-1:0] hlen_q
);

  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> (sclk_o == $past(idle_hi)));

  a_r3_strobe_starts: assert property (@(posedge clk) disable iff (rst)
    (sync_en && bit_stb) |=> (cell_act && cell_half == HALF_A));

  a_r6_len_range: assert property (@(posedge clk) disable iff (rst)
    cell_act |-> (hlen_q >= LEN_W'(2) && hlen_q <= LEN_W'(1 << DIV_W)));

  a_r7_len_held: assert property (@(posedge clk) disable iff (rst)
    (cell_act && sync_en && !bit_stb) |=> $stable(hlen_q));

  a_r8_suppressed_idle: assert property (@(posedge clk) disable iff (rst)
    (cell_act && cell_sup && $stable(idle_hi)) |-> (sclk_o == idle_hi));

  a_r9_idle_between: assert property (@(posedge clk) disable iff (rst)
    (!cell_act && $stable(idle_hi)) |-> (sclk_o == idle_hi));

endmodule

bind sclkgen sclkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_en   (sync_en),
  .idle_hi   (idle_hi),
  .bit_stb   (bit_stb),
  .sclk_o    (sclk_o),
  .cell_act  (cell_act),
  .cell_sup  (cell_sup),
  .cell_half (cell_half),
  .hlen_q    (hlen_q)
);

// File: tb/sclkgen_bench.sv
`timescale 1ns/1ps
module sclkgen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_en = 1'b0;
  logic       idle_hi = 1'b1;
  logic       late_edge = 1'b0;
  logic       last_pulse_en = 1'b1;
  logic [4:0] div_sel = 5'd2;
  logic       bit_stb = 1'b0;
  logic       bit_last = 1'b0;
  logic       sclk_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sclkgen #(.DIV_W(5)) u_sclkgen (
    .clk           (clk),
    .rst           (rst),
    .sync_en       (sync_en),
    .idle_hi       (idle_hi),
    .late_edge     (late_edge),
    .last_pulse_en (last_pulse_en),
    .div_sel       (div_sel),
    .bit_stb       (bit_stb),
    .bit_last      (bit_last),
    .sclk_o        (sclk_o)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // call at a negedge; strobes one cell and samples nsamp cycles of it
  task automatic run_cell(input int dv, input bit pol, input bit ph, input bit lb,
                          input bit last, input int nsamp, input int chg_at,
                          input int new_dv, input string req);
    int  h;
    bit  sup;
    logic exp;
    h   = ((dv == 0) ? 1 : dv) + 1;
    sup = last && !lb;
    sync_en = 1'b1; idle_hi = pol; late_edge = ph; last_pulse_en = lb;
    div_sel = 5'(dv); bit_last = last; bit_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_stb = 1'b0; bit_last = 1'b0;
    for (int i = 0; i < nsamp; i++) begin
      if (i > 0) @(negedge clk);
      exp = (!sup && ((((i / h) % 2) == 1) ^ ph)) ? ~pol : pol;
      chk(sclk_o, exp, req, $sformatf("div=%0d pol=%0d ph=%0d sample %0d", dv, pol, ph, i));
      if (i == chg_at) div_sel = 5'(new_dv);
    end
  endtask

  task automatic check_idle(input bit pol, input string req);
    @(posedge clk);
    @(negedge clk);
    chk(sclk_o, pol, req, "idle after cell");
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_hi = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sclk_o, 1'b1, "R1", "reset level high");
    idle_hi = 1'b0;
    @(negedge clk);
    chk(sclk_o, 1'b0, "R1", "reset level low");
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_o, 1'b0, "R1", "after release");
  endtask

  task automatic t_disabled();
    sync_en = 1'b0; idle_hi = 1'b0; late_edge = 1'b1; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(sclk_o, 1'b0, "R2", "strobe ignored while off");
      @(negedge clk);
    end
  endtask

  task automatic t_modes();
    for (int p = 0; p < 2; p++) begin
      for (int q = 0; q < 2; q++) begin
        run_cell(2, p[0], q[0], 1'b1, 1'b0, 6, -1, 0, "R3 R4 R5");
        check_idle(p[0], "R9");
      end
    end
  endtask

  task automatic t_div_range();
    run_cell(0, 1'b0, 1'b0, 1'b1, 1'b0, 4, -1, 0, "R6");
    check_idle(1'b0, "R6");
    run_cell(1, 1'b0, 1'b1, 1'b1, 1'b0, 4, -1, 0, "R6");
    check_idle(1'b0, "R6");
    run_cell(31, 1'b1, 1'b0, 1'b1, 1'b0, 64, -1, 0, "R6");
    check_idle(1'b1, "R6");
  endtask

  task automatic t_last();
    run_cell(2, 1'b0, 1'b0, 1'b0, 1'b0, 6, -1, 0, "R9");
    run_cell(2, 1'b0, 1'b0, 1'b0, 1'b0, 6, -1, 0, "R9");
    run_cell(2, 1'b0, 1'b0, 1'b0, 1'b1, 6, -1, 0, "R8");
    check_idle(1'b0, "R8");
    run_cell(2, 1'b1, 1'b1, 1'b1, 1'b0, 6, -1, 0, "R9");
    run_cell(2, 1'b1, 1'b1, 1'b1, 1'b1, 6, -1, 0, "R8");
    check_idle(1'b1, "R9");
  endtask

  task automatic t_div_change();
    run_cell(3, 1'b0, 1'b0, 1'b1, 1'b0, 8, 2, 7, "R7");
    run_cell(7, 1'b0, 1'b0, 1'b1, 1'b0, 16, -1, 0, "R7");
    check_idle(1'b0, "R7");
  endtask

  task automatic t_restart();
    run_cell(4, 1'b0, 1'b1, 1'b1, 1'b0, 3, -1, 0, "R10");
    run_cell(4, 1'b0, 1'b1, 1'b1, 1'b0, 10, -1, 0, "R10");
    check_idle(1'b0, "R10");
  endtask

  task automatic t_drop();
    run_cell(4, 1'b0, 1'b1, 1'b1, 1'b0, 2, -1, 0, "R2");
    sync_en = 1'b0;
    check_idle(1'b0, "R2");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(sclk_o, 1'b0, "R2", "stays idle after disable");
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled();
    t_modes();
    t_div_range();
    t_last();
    t_div_change();
    t_restart();
    t_drop();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule